// File: doc/BRIEF.md
# Vectored Interrupt Chain with Priority Acknowledge

This block holds the interrupt logic of a row of peripherals that share one request line and one data bus to a processor, together with the processor-side mask that gates the request before the control unit sees it. Each peripheral slot keeps a pending flag, which an event pulse sets, and an enable flag. A slot with both flags set pulls the shared request line.

The processor answers with an acknowledge that enters slot 0 and ripples toward the last slot. A slot that is requesting when the acknowledge first reaches it absorbs it. A slot that is not requesting hands it on. The slot that absorbs it places its information bits and vector on the data bus and raises a valid strobe. The processor then raises a taken strobe. The slot withdraws its vector and clears its pending flag, and it keeps the acknowledge blocked until the processor lowers it. No slot that is not selected ever puts a nonzero value on the data bus.

Top module: `irq_chain`

## Requirements
- R1: After reset all pending flags, enable flags and the mask bit are 0. A pulse on `dev_event[i]` sets pending flag i. A pulse on `dev_en_set[i]` sets enable flag i, and `dev_en_clr[i]` clears it; clear wins if both pulse together. `dev_req[i]` is high exactly when both flags of slot i are set.
- R2: `irq_line` is the OR of `dev_req`. It goes high on the clock edge that completes both flags of any slot.
- R3: `mask_on` sets the mask bit and `mask_off` clears it; `mask_off` wins if both are given together. `cpu_irq` equals `irq_line` AND the mask bit.
- R4: Slot 0 has the highest priority. When `cpu_ack` rises, the lowest-numbered slot with `dev_req` high is selected. At most one slot is selected at any time.
- R5: One clock edge after the acknowledge rises, the selected slot raises `vec_valid` and drives `data_bus` = {info bits (upper INFO_W bits), vector (lower VEC_W bits)}.
- R6: `data_bus` is zero in every cycle in which `vec_valid` is low.
- R7: `cpu_taken` while `vec_valid` is high drops `vec_valid` and the bus on the next edge and clears that slot's pending flag. If an event arrives in that same cycle, the flag stays set. The slot keeps the acknowledge from passing to lower-priority slots until `cpu_ack` falls.
- R8: A slot whose request appears while the acknowledge is already present at its position does not take that acknowledge. It is served on the next rising edge of `cpu_ack`.
- R9: An acknowledge that arrives while no slot is requesting selects nothing: `vec_valid` stays low and the bus stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_event | input | N_DEV | Per-slot event pulse that sets the pending flag |
| dev_en_set | input | N_DEV | Per-slot pulse that sets the enable flag |
| dev_en_clr | input | N_DEV | Per-slot pulse that clears the enable flag |
| dev_vector | input | N_DEV*VEC_W | Vector of each slot, slot i at bits i*VEC_W |
| dev_info | input | N_DEV*INFO_W | Information bits of each slot, slot i at bits i*INFO_W |
| mask_on | input | 1 | Processor command that lets interrupts through |
| mask_off | input | 1 | Processor command that blocks interrupts |
| cpu_ack | input | 1 | Acknowledge from the processor, entering slot 0 |
| cpu_taken | input | 1 | Processor has latched the vector |
| irq_line | output | 1 | Shared request line (OR of all slots) |
| cpu_irq | output | 1 | Request as seen by the control unit after masking |
| vec_valid | output | 1 | Vector on the data bus is valid |
| data_bus | output | VEC_W+INFO_W | Info and vector of the selected slot, zero otherwise |
| dev_req | output | N_DEV | Per-slot request contribution (pending AND enabled) |

## Verification
The hardest case to reach from the ports is a request that appears in the middle of a transfer, at a slot of higher priority than the one already selected. Only that ordering shows whether capture is tied to the rising edge of the acknowledge or to its level. The stimulus gets there by first letting slot 2 absorb the acknowledge. It then fires an event on slot 0 while `cpu_ack` stays high, checks that the bus still carries slot 2's vector, and finishes that transfer. It then shows that a second acknowledge goes to slot 0. A further case fires a new event in the same cycle as the taken strobe, which checks that the set of the pending flag wins over its clear.

// File: rtl/irq_chain.sv
module irq_chain #(
  parameter int N_DEV  = 4,
  parameter int VEC_W  = 8,
  parameter int INFO_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_DEV-1:0]          dev_event,
  input  logic [N_DEV-1:0]          dev_en_set,
  input  logic [N_DEV-1:0]          dev_en_clr,
  input  logic [N_DEV*VEC_W-1:0]    dev_vector,
  input  logic [N_DEV*INFO_W-1:0]   dev_info,
  input  logic                      mask_on,
  input  logic                      mask_off,
  input  logic                      cpu_ack,
  input  logic                      cpu_taken,
  output logic                      irq_line,
  output logic                      cpu_irq,
  output logic                      vec_valid,
  output logic [VEC_W+INFO_W-1:0]   data_bus,
  output logic [N_DEV-1:0]          dev_req
);
  localparam int DW = VEC_W + INFO_W;

  logic [N_DEV:0]   ack_c;
  logic [N_DEV-1:0] sel_v;
  logic [DW-1:0]    drive [N_DEV];
  logic             mask_q;

  assign ack_c[0] = cpu_ack;

  for (genvar g = 0; g < N_DEV; g++) begin : g_slot
    logic pend_r, en_r, sel_r, done_r, seen_r;
    logic grab, finish;

    assign dev_req[g]  = pend_r & en_r;
    assign grab        = ack_c[g] & ~seen_r & dev_req[g] & ~sel_r & ~done_r;
    assign finish      = sel_r & cpu_taken;
    assign ack_c[g+1]  = ack_c[g] & ~(sel_r | done_r | grab);
    assign sel_v[g]    = sel_r;
    assign drive[g]    = sel_r ? {dev_info[g*INFO_W +: INFO_W], dev_vector[g*VEC_W +: VEC_W]} : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_r <= 1'b0;
        en_r   <= 1'b0;
        sel_r  <= 1'b0;
        done_r <= 1'b0;
        seen_r <= 1'b0;
      end else begin
        seen_r <= ack_c[g];
        if (dev_en_clr[g])      en_r <= 1'b0;
        else if (dev_en_set[g]) en_r <= 1'b1;
        if (dev_event[g])       pend_r <= 1'b1;
        else if (finish)        pend_r <= 1'b0;
        if (finish)             sel_r <= 1'b0;
        else if (grab)          sel_r <= 1'b1;
        if (finish)             done_r <= 1'b1;
        else if (!ack_c[g])     done_r <= 1'b0;
      end
    end

    AST_LATE_NO_GRAB: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_c[g] && seen_r && !sel_r) |=> !sel_r); // R8
    AST_TAKEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (finish && !dev_event[g]) |=> !dev_req[g]); // R7
    AST_GRAB_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_r) |-> $past(dev_req[g])); // R4
  end

  always_comb begin
    data_bus = '0;
    for (int i = 0; i < N_DEV; i++) data_bus = data_bus | drive[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        mask_q <= 1'b0;
    else if (mask_off) mask_q <= 1'b0;
    else if (mask_on)  mask_q <= 1'b1;
  end

  assign vec_valid = |sel_v;
  assign irq_line  = |dev_req;
  assign cpu_irq   = irq_line & mask_q;

  AST_ONE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_v)); // R4
  AST_VALID_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> $past(cpu_ack)); // R5
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && cpu_taken) |=> !vec_valid); // R7
  AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    mask_off |=> !cpu_irq); // R3
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> (data_bus == '0)); // R6
endmodule

// File: tb/sim_irq_chain.sv
module sim_irq_chain;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] dev_event = '0, dev_en_set = '0, dev_en_clr = '0;
  logic [31:0] dev_vector = {8'h4D, 8'h3C, 8'h2B, 8'h1A};
  logic [15:0] dev_info   = {4'h8, 4'h4, 4'h2, 4'h1};
  logic mask_on = 1'b0, mask_off = 1'b0, cpu_ack = 1'b0, cpu_taken = 1'b0;
  logic irq_line, cpu_irq, vec_valid;
  logic [11:0] data_bus;
  logic [N-1:0] dev_req;
  int checks = 0, errors = 0;
  bit finished = 0;

  irq_chain u0 (.clk(clk), .rst_n(rst_n), .dev_event(dev_event), .dev_en_set(dev_en_set),
    .dev_en_clr(dev_en_clr), .dev_vector(dev_vector), .dev_info(dev_info), .mask_on(mask_on),
    .mask_off(mask_off), .cpu_ack(cpu_ack), .cpu_taken(cpu_taken), .irq_line(irq_line),
    .cpu_irq(cpu_irq), .vec_valid(vec_valid), .data_bus(data_bus), .dev_req(dev_req));

  always #4 clk = ~clk;

  function automatic logic [11:0] word(int i);
    return {dev_info[i*4 +: 4], dev_vector[i*8 +: 8]};
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic ev(logic [N-1:0] m);
    dev_event = m; tick(); dev_event = '0;
  endtask

  task automatic complete();
    cpu_taken = 1'b1; tick();
    chk("R7 valid drops", vec_valid, 0);
    chk("R6 bus zero after taken", data_bus, 0);
    cpu_taken = 1'b0; cpu_ack = 1'b0; tick();
  endtask

  task automatic t_reset();
    chk("R1 reset req", dev_req, 0);
    chk("R2 reset line", irq_line, 0);
    chk("R3 reset cpu_irq", cpu_irq, 0);
    chk("R6 reset bus", {vec_valid, data_bus}, 0);
  endtask

  task automatic t_enable();
    ev(4'b0100);
    chk("R1 disabled slot silent", dev_req, 0);
    chk("R2 line low when disabled", irq_line, 0);
    dev_en_set = 4'b0100; tick(); dev_en_set = '0;
    chk("R1 enable exposes held flag", dev_req, 4'b0100);
    chk("R2 line high", irq_line, 1);
    chk("R3 masked by default", cpu_irq, 0);
    dev_en_set = 4'b1000; dev_en_clr = 4'b1000; tick();
    dev_en_set = '0; dev_en_clr = '0;
    ev(4'b1000);
    chk("R1 clear wins over set", dev_req, 4'b0100);
    dev_en_set = 4'b1000; tick(); dev_en_set = '0;
    chk("R1 slot3 now contributes", dev_req, 4'b1100);
    dev_en_clr = 4'b1000; tick(); dev_en_clr = '0;
  endtask

  task automatic t_mask();
    mask_on = 1'b1; tick(); mask_on = 1'b0;
    chk("R3 mask on", cpu_irq, 1);
    mask_on = 1'b1; mask_off = 1'b1; tick(); mask_on = 1'b0; mask_off = 1'b0;
    chk("R3 off wins", cpu_irq, 0);
    mask_on = 1'b1; tick(); mask_on = 1'b0;
    chk("R3 mask on again", cpu_irq, 1);
  endtask

  task automatic t_serve();
    cpu_ack = 1'b1; #1;
    chk("R5 no valid before edge", vec_valid, 0);
    tick();
    chk("R5 valid after ack", vec_valid, 1);
    chk("R5 slot2 word", data_bus, word(2));
    complete();
    chk("R7 flag cleared", dev_req, 0);
    chk("R2 line low after service", irq_line, 0);
  endtask

  task automatic t_priority();
    dev_en_set = 4'b1111; tick(); dev_en_set = '0;
    ev(4'b1010);
    cpu_ack = 1'b1; tick();
    chk("R4 slot1 beats slot3", data_bus, word(1));
    cpu_taken = 1'b1; tick(); cpu_taken = 1'b0; tick();
    chk("R7 ack held blocked", vec_valid, 0);
    chk("R7 slot3 still pending", dev_req, 4'b1000);
    cpu_ack = 1'b0; tick();
    cpu_ack = 1'b1; tick();
    chk("R4 slot3 served next", data_bus, word(3));
    complete();
  endtask

  task automatic t_late();
    ev(4'b0100);
    cpu_ack = 1'b1; tick();
    chk("R8 slot2 selected", data_bus, word(2));
    ev(4'b0001);
    tick();
    chk("R8 late slot0 not grabbing", data_bus, word(2));
    chk("R8 slot0 pending", dev_req, 4'b0101);
    complete();
    chk("R8 line still high", irq_line, 1);
    cpu_ack = 1'b1; tick();
    chk("R8 slot0 on next ack", data_bus, word(0));
    complete();
  endtask

  task automatic t_empty();
    cpu_ack = 1'b1; tick(); tick();
    chk("R9 no select", vec_valid, 0);
    chk("R9 bus zero", data_bus, 0);
    cpu_ack = 1'b0; tick();
  endtask

  task automatic t_set_wins();
    ev(4'b0010);
    cpu_ack = 1'b1; tick();
    chk("R5 slot1 word", data_bus, word(1));
    cpu_taken = 1'b1; dev_event = 4'b0010; tick();
    dev_event = '0; cpu_taken = 1'b0;
    chk("R7 valid off", vec_valid, 0);
    chk("R7 event wins", dev_req, 4'b0010);
    cpu_ack = 1'b0; tick();
    cpu_ack = 1'b1; tick();
    chk("R7 re-served", data_bus, word(1));
    complete();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1; tick();
    t_reset();
    t_enable();
    t_mask();
    t_serve();
    t_priority();
    t_late();
    t_empty();
    t_set_wins();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule